// File: doc/BRIEF.md
# System Controller Register Bank

This block is a bank of 32-bit housekeeping registers on a simple word-oriented bus. Software reaches the general-purpose input, output and interrupt-enable registers, a debug scratchpad with a sticky lock flag, and three constant registers that report the clock frequency, a capabilities word and a system identifier. The general-purpose inputs pass through a synchronizer before software sees them. A change on an enabled input bit raises a one-cycle interrupt pulse.

Two addresses behave as command ports rather than storage. Writing a particular 16-bit command to the configuration port emits a one-cycle shutdown request. Any write to the identifier register emits a one-cycle system reset request. The surrounding chip acts on both requests. Reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is sampled high.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, these registers read as follows: word 0 (GPIO input) reads the strapping value 0x00000001; word 29 (clock frequency) reads 80000000; word 30 (capabilities) reads 0; word 31 (system identifier) reads 0x10014D31; word 16 (configuration port) reads 1. Words 1, 2, 20 and 21 read 0.
- R2: The register index is the byte address divided by four. Address bits 1:0 have no effect on reads or writes.
- R3: Word 1 (GPIO output), word 2 (interrupt enable) and word 20 (scratchpad) are read/write. The GPIO output value drives the gpioOut port. Word 1 and word 2 store only the low GPIO_W bits, and their upper bits read as zero.
- R4: Writes to word 0, word 29 and word 30 leave their read values unchanged.
- R5: A write to word 16 whose bits 15:0 equal 0x000E raises shutdownReq for exactly the one cycle after the write edge, whatever bits 31:16 hold. Any other data raises no request. Word 16 always reads 1.
- R6: Any write to word 21 sets it to read 1, whatever the data (0 included). It then stays 1 until reset.
- R7: Any write to word 31 raises resetReq for exactly the one cycle after the write edge. Word 31 still reads 0x10014D31 afterwards.
- R8: Words that are not mapped read as zero. Writes to them change no register and raise no request.
- R9: Word 0 follows the gpioPins input with a latency of SYNC_STAGES clock edges (2 by default).
- R10: gpioIrq pulses high for one cycle, in the same cycle in which word 0 first shows a change. The pulse occurs only if a changed bit has its interrupt-enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrite | input | 1 | Write strobe, sampled at the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| gpioPins | input | GPIO_W | Asynchronous general-purpose inputs |
| gpioOut | output | GPIO_W | General-purpose output register value |
| gpioIrq | output | 1 | One-cycle pulse on an enabled input change |
| shutdownReq | output | 1 | One-cycle shutdown request |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The bench aims at the command decode. A shutdown code with non-zero upper bits must still fire. A non-matching code, or the code placed in the upper half, must not fire. A decoder that compared all 32 bits, or the wrong half, would miss one of these cases. The lock is written with zero data, to catch a design that stores the data instead of setting the flag. The identifier and the constant registers are written and read back, to catch a design that lets the reset-triggering write or a stray write land in storage. Unmapped words and unaligned addresses are also written, to catch incomplete decode or aliasing. On the input side, the bench changes a masked bit and then an enabled bit, and expects the interrupt only in the cycle the synchronized value appears.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // Word indices; software depends on these positions.
  localparam int IDX_GPIO_IN  = 0;
  localparam int IDX_GPIO_OUT = 1;
  localparam int IDX_INT_EN   = 2;
  localparam int IDX_CFG_PORT = 16;
  localparam int IDX_SCRATCH  = 20;
  localparam int IDX_LOCK     = 21;
  localparam int IDX_CLK_HZ   = 29;
  localparam int IDX_CAPS     = 30;
  localparam int IDX_SYS_ID   = 31;

  localparam logic [15:0] SHUTDOWN_CMD = 16'h000E;
  localparam logic [31:0] CFG_READY    = 32'h0000_0001;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_GPIO_IN,
    SEL_GPIO_OUT,
    SEL_INT_EN,
    SEL_CFG,
    SEL_SCRATCH,
    SEL_LOCK,
    SEL_CLK,
    SEL_CAPS,
    SEL_SYS_ID
  } regSel_e;

  typedef struct packed {
    logic    wrGpioOut;
    logic    wrIntEn;
    logic    wrScratch;
    logic    setLock;
    logic    reqShutdown;
    logic    reqReset;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int WORD_W = 5
) (
  input  logic [WORD_W-1:0] wordIdx,
  input  logic              busWrite,
  input  logic [15:0]       cmdBits,
  output ctrlStrobe_t       strb
);

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    case (int'(wordIdx))
      IDX_GPIO_IN:  strb.rdSel = SEL_GPIO_IN;
      IDX_GPIO_OUT: begin
        strb.rdSel     = SEL_GPIO_OUT;
        strb.wrGpioOut = busWrite;
      end
      IDX_INT_EN: begin
        strb.rdSel   = SEL_INT_EN;
        strb.wrIntEn = busWrite;
      end
      IDX_CFG_PORT: begin
        strb.rdSel       = SEL_CFG;
        strb.reqShutdown = busWrite && (cmdBits == SHUTDOWN_CMD);
      end
      IDX_SCRATCH: begin
        strb.rdSel     = SEL_SCRATCH;
        strb.wrScratch = busWrite;
      end
      IDX_LOCK: begin
        strb.rdSel   = SEL_LOCK;
        strb.setLock = busWrite;
      end
      IDX_CLK_HZ:   strb.rdSel = SEL_CLK;
      IDX_CAPS:     strb.rdSel = SEL_CAPS;
      IDX_SYS_ID: begin
        strb.rdSel    = SEL_SYS_ID;
        strb.reqReset = busWrite;
      end
      default:      strb.rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/sysctl_datapath.sv
module sysctl_datapath
  import sysctl_pkg::*;
#(
  parameter int               GPIO_W      = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [GPIO_W-1:0] GPIO_STRAP = 1,
  parameter logic [31:0]      CLK_HZ      = 32'd80000000,
  parameter logic [31:0]      CAPS        = 32'h0,
  parameter logic [31:0]      SYS_ID      = 32'h10014D31
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [31:0]       busWdata,
  input  logic [GPIO_W-1:0] gpioPins,
  output logic [31:0]       busRdata,
  output logic [GPIO_W-1:0] gpioOut,
  output logic              gpioIrq,
  output logic              shutdownReq,
  output logic              resetReq
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][GPIO_W-1:0] syncQ;
  logic [GPIO_W-1:0] gpioOutQ;
  logic [GPIO_W-1:0] intEnQ;
  logic [31:0]       scratchQ;
  logic              lockQ;
  logic [GPIO_W-1:0] gpioIn;
  logic [GPIO_W-1:0] edgeHit;

  assign gpioIn  = syncQ[LAST];
  assign edgeHit = (syncQ[LAST-1] ^ syncQ[LAST]) & intEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= GPIO_STRAP;
    end else begin
      syncQ[0] <= gpioPins;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gpioOutQ    <= '0;
      intEnQ      <= '0;
      scratchQ    <= '0;
      lockQ       <= 1'b0;
      gpioIrq     <= 1'b0;
      shutdownReq <= 1'b0;
      resetReq    <= 1'b0;
    end else begin
      if (strb.wrGpioOut) gpioOutQ <= busWdata[GPIO_W-1:0];
      if (strb.wrIntEn)   intEnQ   <= busWdata[GPIO_W-1:0];
      if (strb.wrScratch) scratchQ <= busWdata;
      if (strb.setLock)   lockQ    <= 1'b1;
      gpioIrq     <= |edgeHit;
      shutdownReq <= strb.reqShutdown;
      resetReq    <= strb.reqReset;
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_GPIO_IN:  busRdata = 32'(gpioIn);
      SEL_GPIO_OUT: busRdata = 32'(gpioOutQ);
      SEL_INT_EN:   busRdata = 32'(intEnQ);
      SEL_CFG:      busRdata = CFG_READY;
      SEL_SCRATCH:  busRdata = scratchQ;
      SEL_LOCK:     busRdata = {31'b0, lockQ};
      SEL_CLK:      busRdata = CLK_HZ;
      SEL_CAPS:     busRdata = CAPS;
      SEL_SYS_ID:   busRdata = SYS_ID;
      default:      busRdata = 32'h0;
    endcase
  end

  assign gpioOut = gpioOutQ;

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter int                GPIO_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [GPIO_W-1:0] GPIO_STRAP  = 1,
  parameter logic [31:0]       CLK_HZ      = 32'd80000000,
  parameter logic [31:0]       CAPS        = 32'h0,
  parameter logic [31:0]       SYS_ID      = 32'h10014D31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [GPIO_W-1:0] gpioPins,
  output logic [GPIO_W-1:0] gpioOut,
  output logic              gpioIrq,
  output logic              shutdownReq,
  output logic              resetReq
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              unusedAddrLsb;
  ctrlStrobe_t       strb;

  assign wordIdx       = busAddr[ADDR_W-1:2];
  assign unusedAddrLsb = ^busAddr[1:0];

  sysctl_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .wordIdx (wordIdx),
    .busWrite(busWrite),
    .cmdBits (busWdata[15:0]),
    .strb    (strb)
  );

  sysctl_datapath #(
    .GPIO_W     (GPIO_W),
    .SYNC_STAGES(SYNC_STAGES),
    .GPIO_STRAP (GPIO_STRAP),
    .CLK_HZ     (CLK_HZ),
    .CAPS       (CAPS),
    .SYS_ID     (SYS_ID)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWdata   (busWdata),
    .gpioPins   (gpioPins),
    .busRdata   (busRdata),
    .gpioOut    (gpioOut),
    .gpioIrq    (gpioIrq),
    .shutdownReq(shutdownReq),
    .resetReq   (resetReq)
  );

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int          ADDR_W = 7,
  parameter logic [31:0] CLK_HZ = 32'd80000000,
  parameter logic [31:0] CAPS   = 32'h0,
  parameter logic [31:0] SYS_ID = 32'h10014D31
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic [15:0]       cmdLow,
  input logic [31:0]       busRdata,
  input logic              shutdownReq,
  input logic              resetReq
);

  logic [ADDR_W-3:0] idx;
  logic              mapped;
  assign idx = busAddr[ADDR_W-1:2];

  always_comb begin
    case (int'(idx))
      0, 1, 2, 16, 20, 21, 29, 30, 31: mapped = 1'b1;
      default:                         mapped = 1'b0;
    endcase
  end

  // R5: a shutdown request only follows a matching command write
  assert_shutdown_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(busWrite && int'(idx) == 16 && cmdLow == 16'h000E));

  // R5: configuration port reads ready
  assert_cfg_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    int'(idx) == 16 |-> busRdata == 32'h1);

  // R7: a reset request only follows a write to the identifier word
  assert_reset_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(busWrite && int'(idx) == 31));

  // R7: identifier never changes
  assert_sysid_const_R7: assert property (@(posedge clk) disable iff (!rstN)
    int'(idx) == 31 |-> busRdata == SYS_ID);

  // R4: constant registers keep their values
  assert_clk_const_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(idx) == 29 |-> busRdata == CLK_HZ);
  assert_caps_const_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(idx) == 30 |-> busRdata == CAPS);

  // R6: lock reads one after any write to it
  assert_lock_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busWrite && int'(idx) == 21) && int'(idx) == 21) |-> busRdata == 32'h1);

  // R8: unmapped words read zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> busRdata == 32'h0);

endmodule

bind sysctl_regbank sysctl_regbank_chk #(
  .ADDR_W(ADDR_W),
  .CLK_HZ(CLK_HZ),
  .CAPS  (CAPS),
  .SYS_ID(SYS_ID)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrite   (busWrite),
  .cmdLow     (busWdata[15:0]),
  .busRdata   (busRdata),
  .shutdownReq(shutdownReq),
  .resetReq   (resetReq)
);

// File: tb/sysctl_regbank_test.sv
module sysctl_regbank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  gpioPins = 8'h01;
  logic [7:0]  gpioOut;
  logic        gpioIrq, shutdownReq, resetReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          useData;
    logic [31:0] data;
    logic        shut, rst, irq;
    bit          useOut;
    logic [7:0]  outExp;
    string       req;
  } item_t;

  item_t q[$];
  item_t it;

  always #4 clk = ~clk;

  sysctl_regbank uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .gpioPins(gpioPins),
    .gpioOut(gpioOut), .gpioIrq(gpioIrq), .shutdownReq(shutdownReq),
    .resetReq(resetReq)
  );

  task automatic cycle(input logic [6:0] a, input logic we, input logic [31:0] wd,
                       input bit useData, input logic [31:0] d, input logic shut,
                       input logic rst, input logic irq, input bit useOut,
                       input logic [7:0] oe, input string req);
    item_t n;
    @(negedge clk);
    busAddr = a; busWrite = we; busWdata = wd;
    n.useData = useData; n.data = d; n.shut = shut; n.rst = rst; n.irq = irq;
    n.useOut = useOut; n.outExp = oe; n.req = req;
    q.push_back(n);
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] d, input string req);
    cycle(a, 1'b0, 32'h0, 1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, req);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] wd, input string req);
    cycle(a, 1'b1, wd, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, req);
  endtask

  task automatic pinCycle(input logic [7:0] v, input string req);
    item_t n;
    @(negedge clk);
    busWrite = 1'b0; busAddr = 7'h0C; gpioPins = v;
    n.useData = 1'b0; n.data = 0; n.shut = 0; n.rst = 0; n.irq = 0;
    n.useOut = 1'b0; n.outExp = 0; n.req = req;
    q.push_back(n);
  endtask

  // Monitor: compares one expected item per cycle, 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() != 0) begin
        bit ok;
        it = q.pop_front();
        checks++;
        ok = (shutdownReq === it.shut) && (resetReq === it.rst) && (gpioIrq === it.irq);
        if (it.useData && busRdata !== it.data) ok = 1'b0;
        if (it.useOut && gpioOut !== it.outExp) ok = 1'b0;
        if (!ok) begin
          errors++;
          $display("FAIL %s: rdata=%h exp=%h shut=%b exp=%b rst=%b exp=%b irq=%b exp=%b out=%h exp=%h",
                   it.req, busRdata, it.data, shutdownReq, it.shut, resetReq, it.rst,
                   gpioIrq, it.irq, gpioOut, it.outExp);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rd(7'h00, 32'h1, "R1 gpio in");
    rd(7'h04, 32'h0, "R1 gpio out");
    rd(7'h08, 32'h0, "R1 int enable");
    rd(7'h40, 32'h1, "R1 cfg ready");
    rd(7'h50, 32'h0, "R1 scratch");
    rd(7'h54, 32'h0, "R1 lock");
    rd(7'h74, 32'd80000000, "R1 clock freq");
    rd(7'h78, 32'h0, "R1 caps");
    rd(7'h7C, 32'h10014D31, "R1 system id");

    // R3 read/write registers
    wr(7'h04, 32'hFFFF_FFA5, "R3 wr gpio out");
    cycle(7'h04, 1'b0, 32'h0, 1'b1, 32'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, "R3 gpio out");
    wr(7'h08, 32'h5A5A_5A04, "R3 wr int enable");
    rd(7'h08, 32'h04, "R3 int enable");
    wr(7'h50, 32'hDEAD_BEEF, "R3 wr scratch");
    rd(7'h50, 32'hDEAD_BEEF, "R3 scratch");

    // R2 low address bits ignored
    wr(7'h53, 32'h1234_5678, "R2 wr unaligned");
    rd(7'h50, 32'h1234_5678, "R2 aligned read");
    rd(7'h52, 32'h1234_5678, "R2 unaligned read");

    // R4 read-only words
    wr(7'h00, 32'hFFFF_FFFF, "R4 wr gpio in");
    wr(7'h74, 32'h0, "R4 wr clock");
    wr(7'h78, 32'hFFFF_FFFF, "R4 wr caps");
    rd(7'h00, 32'h1, "R4 gpio in");
    rd(7'h74, 32'd80000000, "R4 clock");
    rd(7'h78, 32'h0, "R4 caps");

    // R5 shutdown command
    cycle(7'h40, 1'b1, 32'hABCD_000E, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0, "R5 shutdown");
    rd(7'h40, 32'h1, "R5 pulse ends, cfg ready");
    wr(7'h40, 32'h0000_000F, "R5 wrong code");
    wr(7'h40, 32'h000E_0000, "R5 code in upper half");
    rd(7'h40, 32'h1, "R5 cfg ready");

    // R6 sticky lock
    wr(7'h54, 32'h0, "R6 wr lock zero");
    rd(7'h54, 32'h1, "R6 lock set");
    wr(7'h54, 32'hFFFF_FFFE, "R6 wr lock again");
    rd(7'h54, 32'h1, "R6 lock stays");

    // R7 reset request
    cycle(7'h7C, 1'b1, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0, "R7 reset req");
    rd(7'h7C, 32'h10014D31, "R7 id unchanged");

    // R8 unmapped words
    wr(7'h0C, 32'hFFFF_FFFF, "R8 wr word 3");
    rd(7'h0C, 32'h0, "R8 word 3");
    wr(7'h64, 32'hFFFF_FFFF, "R8 wr word 25");
    rd(7'h64, 32'h0, "R8 word 25");
    rd(7'h50, 32'h1234_5678, "R8 scratch untouched");
    cycle(7'h04, 1'b0, 32'h0, 1'b1, 32'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, "R8 gpio out untouched");

    // R9/R10 inputs and interrupt (enable mask is 0x04)
    pinCycle(8'h03, "R10 masked change, first edge");
    cycle(7'h00, 1'b0, 32'h0, 1'b1, 32'h03, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, "R9 sync value, R10 no irq");
    rd(7'h00, 32'h03, "R10 quiet");
    pinCycle(8'h07, "R10 enabled change, first edge");
    cycle(7'h00, 1'b0, 32'h0, 1'b1, 32'h07, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0, "R9 sync value, R10 irq");
    rd(7'h00, 32'h07, "R10 irq one cycle");

    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule